// File: doc/BRIEF.md
# Predicate Register File with Typed Deposits

This block holds a bank of one-bit predicate registers for a statically scheduled, in-order core that conditions instructions on guard predicates. Several compare lanes can deposit into the file in the same cycle. Each deposit names a destination register and a deposit kind, and carries the guard predicate value and the compare result. The block turns each deposit into a write of 1, a write of 0, or no write, and merges all lanes into one update per register.

Two read ports return guard values by index. A whole-file word view lets software save and restore every predicate at once, for example on calls or context switches. Two mask inputs force groups of registers to 0 or to 1, which is how registers are prepared before parallel-compare chains that need a known start value.

All updates take effect at the rising clock edge. Reads always return the value held before that edge. Entry 0 is a constant-true guard. `NUM_PREDS` must be a power of two.

Top module: `pred_file`

## Requirements
- R1: Entry 0 always reads as 1. Deposits, masks and word loads addressed to bit 0 have no effect on it.
- R2: Kind codes 0 and 1 are the unconditional kinds (true and complement). With guard 0 they write 0. With guard 1 they write the compare result (code 0) or its inverse (code 1).
- R3: Kind codes 2 and 3 are the or-kinds. They write 1 when the guard is 1 and the result is 1 (code 2) or 0 (code 3). Otherwise they do not write.
- R4: Kind codes 4 and 5 are the and-kinds. They write 0 when the guard is 1 and the result is 0 (code 4) or 1 (code 5). Otherwise they do not write.
- R5: Kind codes 6 and 7 are the conditional kinds. With guard 1 they write the result (code 6) or its inverse (code 7). With guard 0 they do not write.
- R6: Kind codes 8 and 9 are the disjunctive kinds. They write 1 when the guard is 1 or the result is 1 (code 8) or 0 (code 9). Otherwise they do not write.
- R7: Kind codes 10 and 11 are the conjunctive kinds. They write 0 when the guard is 0 or the result is 0 (code 10) or 1 (code 11). Otherwise they do not write. Codes 12 to 15 and lanes with valid low never write.
- R8: Deposits from several lanes to one register in a cycle all take effect. Writes of 1 combine as an OR and writes of 0 as an AND. If the same register other than entry 0 receives both a write of 1 and a write of 0, the 0 wins and `conflict_o` is high in that same cycle.
- R9: Bits set in `clr_mask_i` become 0 and bits set in `set_mask_i` become 1. Where both are set, set wins. A deposit to a register in the same cycle overrides both masks.
- R10: `coll_rdata_o` shows all predicates as one word, with bit i holding register i. When `coll_we_i` is high, bits 1 and up load from `coll_wdata_i`, and all masks and deposits of that cycle are discarded.
- R11: `rd_val0_o` and `rd_val1_o` return the register chosen by their index. All reads reflect the state before the current cycle's updates, which appear after the next rising edge. With no operation the state holds.
- R12: After reset every register except entry 0 holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dep_valid_i | input | NUM_LANES | Deposit valid, one per lane |
| dep_idx_i | input | NUM_LANES*IDX_W | Destination index per lane, lane 0 in the low bits |
| dep_kind_i | input | NUM_LANES*4 | Deposit kind code per lane |
| dep_guard_i | input | NUM_LANES | Guard predicate value per lane |
| dep_cmp_i | input | NUM_LANES | Compare result per lane |
| clr_mask_i | input | NUM_PREDS | Registers forced to 0 |
| set_mask_i | input | NUM_PREDS | Registers forced to 1 |
| coll_we_i | input | 1 | Load the whole file from coll_wdata_i |
| coll_wdata_i | input | NUM_PREDS | Word to load |
| coll_rdata_o | output | NUM_PREDS | Whole file as one word |
| rd_idx0_i | input | IDX_W | Read port 0 index |
| rd_val0_o | output | 1 | Read port 0 value |
| rd_idx1_i | input | IDX_W | Read port 1 index |
| rd_val1_o | output | 1 | Read port 1 value |
| conflict_o | output | 1 | Same-cycle write of 1 and write of 0 to one register |

## Verification
An exhaustive sweep drives every kind code against every guard, compare result and prior register value. This separates the kinds that leave a register untouched from those that overwrite it, and each true form from its complement. Directed multi-lane patterns aim parallel deposits at one register, both with matching values and with opposite values. These patterns tell wired-OR and wired-AND merging apart from a conflict where the 0 must win. Further cases overlap masks with each other and with deposits, start word loads in cycles that are also busy, and address entry 0 through every path. Long stretches of mixed random traffic then compare every output against a behavioural model on every clock.

// File: rtl/pred_pkg.sv
package pred_pkg;

    typedef enum logic [3:0] {
        KIND_UNC_T = 4'd0,
        KIND_UNC_F = 4'd1,
        KIND_OR_T  = 4'd2,
        KIND_OR_F  = 4'd3,
        KIND_AND_T = 4'd4,
        KIND_AND_F = 4'd5,
        KIND_CND_T = 4'd6,
        KIND_CND_F = 4'd7,
        KIND_DIS_T = 4'd8,
        KIND_DIS_F = 4'd9,
        KIND_CON_T = 4'd10,
        KIND_CON_F = 4'd11
    } dep_kind_e;

    typedef struct packed {
        logic wr_one;
        logic wr_zero;
    } dep_act_t;

    // Bit 0 of every kind code selects the complement form.
    function automatic dep_act_t dep_resolve(input logic [3:0] kind,
                                             input logic guard,
                                             input logic cmp);
        dep_act_t act;
        logic     eff;
        eff = cmp ^ kind[0];
        act = '0;
        case (kind)
            KIND_UNC_T, KIND_UNC_F: begin
                act.wr_one  = guard & eff;
                act.wr_zero = ~(guard & eff);
            end
            KIND_OR_T, KIND_OR_F:   act.wr_one  = guard & eff;
            KIND_AND_T, KIND_AND_F: act.wr_zero = guard & ~eff;
            KIND_CND_T, KIND_CND_F: begin
                act.wr_one  = guard & eff;
                act.wr_zero = guard & ~eff;
            end
            KIND_DIS_T, KIND_DIS_F: act.wr_one  = guard | eff;
            KIND_CON_T, KIND_CON_F: act.wr_zero = ~guard | ~eff;
            default:                act = '0;
        endcase
        return act;
    endfunction

endpackage

// File: rtl/pred_lane_decode.sv
module pred_lane_decode #(
    parameter int NUM_PREDS = 32,
    parameter int IDX_W     = $clog2(NUM_PREDS)
) (
    input  logic                 valid_i,
    input  logic [IDX_W-1:0]     idx_i,
    input  logic [3:0]           kind_i,
    input  logic                 guard_i,
    input  logic                 cmp_i,
    output logic [NUM_PREDS-1:0] one_vec_o,
    output logic [NUM_PREDS-1:0] zero_vec_o
);
    import pred_pkg::*;

    localparam logic [NUM_PREDS-1:0] LSB_ONE = {{(NUM_PREDS-1){1'b0}}, 1'b1};

    dep_act_t             act;
    logic [NUM_PREDS-1:0] target;

    always_comb begin
        act    = dep_resolve(kind_i, guard_i, cmp_i);
        // Entry 0 is excluded from every deposit.
        target = (LSB_ONE << idx_i) & ~LSB_ONE;
        one_vec_o  = (valid_i && act.wr_one)  ? target : '0;
        zero_vec_o = (valid_i && act.wr_zero) ? target : '0;
    end

endmodule

// File: rtl/pred_deposit_merge.sv
module pred_deposit_merge #(
    parameter int NUM_PREDS = 32,
    parameter int NUM_LANES = 4
) (
    input  logic [NUM_LANES-1:0][NUM_PREDS-1:0] one_vecs_i,
    input  logic [NUM_LANES-1:0][NUM_PREDS-1:0] zero_vecs_i,
    output logic [NUM_PREDS-1:0]                set_any_o,
    output logic [NUM_PREDS-1:0]                clr_any_o,
    output logic                                conflict_o
);
    always_comb begin
        set_any_o = '0;
        clr_any_o = '0;
        for (int l = 0; l < NUM_LANES; l++) begin
            set_any_o = set_any_o | one_vecs_i[l];
            clr_any_o = clr_any_o | zero_vecs_i[l];
        end
        conflict_o = |(set_any_o & clr_any_o);
    end

endmodule

// File: rtl/pred_read_port.sv
module pred_read_port #(
    parameter int NUM_PREDS = 32,
    parameter int IDX_W     = $clog2(NUM_PREDS)
) (
    input  logic [NUM_PREDS-1:0] preds_i,
    input  logic [IDX_W-1:0]     idx_i,
    output logic                 val_o
);
    always_comb val_o = preds_i[idx_i];

endmodule

// File: rtl/pred_file.sv
module pred_file #(
    parameter int NUM_PREDS = 32,   // power of two
    parameter int NUM_LANES = 4,
    parameter int IDX_W     = $clog2(NUM_PREDS)
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic [NUM_LANES-1:0]           dep_valid_i,
    input  logic [NUM_LANES*IDX_W-1:0]     dep_idx_i,
    input  logic [NUM_LANES*4-1:0]         dep_kind_i,
    input  logic [NUM_LANES-1:0]           dep_guard_i,
    input  logic [NUM_LANES-1:0]           dep_cmp_i,
    input  logic [NUM_PREDS-1:0]           clr_mask_i,
    input  logic [NUM_PREDS-1:0]           set_mask_i,
    input  logic                           coll_we_i,
    input  logic [NUM_PREDS-1:0]           coll_wdata_i,
    output logic [NUM_PREDS-1:0]           coll_rdata_o,
    input  logic [IDX_W-1:0]               rd_idx0_i,
    output logic                           rd_val0_o,
    input  logic [IDX_W-1:0]               rd_idx1_i,
    output logic                           rd_val1_o,
    output logic                           conflict_o
);
    localparam int NUM_RD = 2;
    localparam logic [NUM_PREDS-1:0] RESET_VAL = {{(NUM_PREDS-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [NUM_PREDS-1:0] preds;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_LANES-1:0][NUM_PREDS-1:0] one_vecs, zero_vecs;
    logic [NUM_PREDS-1:0]                dep_set, dep_clr;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        pred_lane_decode #(.NUM_PREDS(NUM_PREDS), .IDX_W(IDX_W)) dec_i (
            .valid_i   (dep_valid_i[l]),
            .idx_i     (dep_idx_i[l*IDX_W +: IDX_W]),
            .kind_i    (dep_kind_i[l*4 +: 4]),
            .guard_i   (dep_guard_i[l]),
            .cmp_i     (dep_cmp_i[l]),
            .one_vec_o (one_vecs[l]),
            .zero_vec_o(zero_vecs[l])
        );
    end

    pred_deposit_merge #(.NUM_PREDS(NUM_PREDS), .NUM_LANES(NUM_LANES)) merge_i (
        .one_vecs_i (one_vecs),
        .zero_vecs_i(zero_vecs),
        .set_any_o  (dep_set),
        .clr_any_o  (dep_clr),
        .conflict_o (conflict_o)
    );

    logic [NUM_RD-1:0][IDX_W-1:0] rd_idx;
    logic [NUM_RD-1:0]            rd_val;
    assign rd_idx[0] = rd_idx0_i;
    assign rd_idx[1] = rd_idx1_i;

    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        pred_read_port #(.NUM_PREDS(NUM_PREDS), .IDX_W(IDX_W)) rd_i (
            .preds_i(state_q.preds),
            .idx_i  (rd_idx[r]),
            .val_o  (rd_val[r])
        );
    end

    assign rd_val0_o    = rd_val[0];
    assign rd_val1_o    = rd_val[1];
    assign coll_rdata_o = state_q.preds;

    always_comb begin
        state_d = state_q;
        if (coll_we_i) begin
            state_d.preds = coll_wdata_i;
        end else begin
            state_d.preds = (state_q.preds & ~clr_mask_i) | set_mask_i;
            state_d.preds = (state_d.preds | dep_set) & ~dep_clr;
        end
        state_d.preds[0] = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q.preds <= RESET_VAL;
        else         state_q       <= state_d;
    end

endmodule

// File: rtl/pred_file_chk.sv
module pred_file_chk #(
    parameter int NUM_PREDS = 32,
    parameter int NUM_LANES = 4,
    parameter int IDX_W     = $clog2(NUM_PREDS)
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic [NUM_LANES-1:0]       dep_valid_i,
    input logic [NUM_PREDS-1:0]       clr_mask_i,
    input logic [NUM_PREDS-1:0]       set_mask_i,
    input logic                       coll_we_i,
    input logic [NUM_PREDS-1:0]       coll_wdata_i,
    input logic [NUM_PREDS-1:0]       coll_rdata_o,
    input logic [IDX_W-1:0]           rd_idx0_i,
    input logic                       rd_val0_o,
    input logic [IDX_W-1:0]           rd_idx1_i,
    input logic                       rd_val1_o
);
    p_entry0_true_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        coll_rdata_o[0] == 1'b1);

    p_rd0_view_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_val0_o == coll_rdata_o[rd_idx0_i]);

    p_rd1_view_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_val1_o == coll_rdata_o[rd_idx1_i]);

    p_word_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        coll_we_i |=> coll_rdata_o[NUM_PREDS-1:1] == $past(coll_wdata_i[NUM_PREDS-1:1]));

    p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!coll_we_i && dep_valid_i == '0 && clr_mask_i == '0 && set_mask_i == '0)
        |=> $stable(coll_rdata_o));

    p_set_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!coll_we_i && dep_valid_i == '0)
        |=> (coll_rdata_o & $past(set_mask_i)) == $past(set_mask_i));

endmodule

bind pred_file pred_file_chk #(
    .NUM_PREDS(NUM_PREDS), .NUM_LANES(NUM_LANES), .IDX_W(IDX_W)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dep_valid_i (dep_valid_i),
    .clr_mask_i  (clr_mask_i),
    .set_mask_i  (set_mask_i),
    .coll_we_i   (coll_we_i),
    .coll_wdata_i(coll_wdata_i),
    .coll_rdata_o(coll_rdata_o),
    .rd_idx0_i   (rd_idx0_i),
    .rd_val0_o   (rd_val0_o),
    .rd_idx1_i   (rd_idx1_i),
    .rd_val1_o   (rd_val1_o)
);

// File: tb/pred_file_tb.sv
`timescale 1ns/1ps
module pred_file_tb_top;
    localparam int N  = 32;
    localparam int L  = 4;
    localparam int IW = 5;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [L-1:0]        dep_valid = '0;
    logic [L*IW-1:0]     dep_idx = '0;
    logic [L*4-1:0]      dep_kind = '0;
    logic [L-1:0]        dep_guard = '0;
    logic [L-1:0]        dep_cmp = '0;
    logic [N-1:0]        clr_mask = '0, set_mask = '0;
    logic                coll_we = 1'b0;
    logic [N-1:0]        coll_wdata = '0;
    logic [N-1:0]        coll_rdata;
    logic [IW-1:0]       rd_idx0 = '0, rd_idx1 = '0;
    logic                rd_val0, rd_val1, conflict;

    int  errors = 0;
    int  checks = 0;
    bit  finished = 0;
    bit [N-1:0] model;

    always #2 clk = ~clk;

    pred_file #(.NUM_PREDS(N), .NUM_LANES(L)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .dep_valid_i(dep_valid), .dep_idx_i(dep_idx), .dep_kind_i(dep_kind),
        .dep_guard_i(dep_guard), .dep_cmp_i(dep_cmp),
        .clr_mask_i(clr_mask), .set_mask_i(set_mask),
        .coll_we_i(coll_we), .coll_wdata_i(coll_wdata), .coll_rdata_o(coll_rdata),
        .rd_idx0_i(rd_idx0), .rd_val0_o(rd_val0),
        .rd_idx1_i(rd_idx1), .rd_val1_o(rd_val1),
        .conflict_o(conflict)
    );

    task automatic check(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Spec of one deposit: returns 1 = write one, 0 = write zero, -1 = none.
    function automatic int spec_deposit(int kind, bit g, bit c);
        bit e;
        e = c ^ kind[0];
        case (kind)
            0, 1:  return (g && e) ? 1 : 0;
            2, 3:  return (g && e) ? 1 : -1;
            4, 5:  return (g && !e) ? 0 : -1;
            6, 7:  return g ? int'(e) : -1;
            8, 9:  return (g || e) ? 1 : -1;
            10, 11: return (!g || !e) ? 0 : -1;
            default: return -1;
        endcase
    endfunction

    function automatic string tag_of_kind(int kind);
        case (kind / 2)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Compare outputs before the edge, then advance the model across it.
    task automatic step(string tag);
        bit [N-1:0] ones, zeros, nxt;
        bit         exp_conf;
        ones = '0; zeros = '0;
        for (int l = 0; l < L; l++) begin
            if (dep_valid[l]) begin
                int w;
                int ix;
                w  = spec_deposit(int'(dep_kind[l*4 +: 4]), dep_guard[l], dep_cmp[l]);
                ix = int'(dep_idx[l*IW +: IW]);
                if (ix != 0 && w == 1) ones[ix]  = 1'b1;
                if (ix != 0 && w == 0) zeros[ix] = 1'b1;
            end
        end
        exp_conf = |(ones & zeros);
        @(negedge clk);
        check(tag, "coll_rdata", coll_rdata, model);
        check(tag, "rd_val0", {{(N-1){1'b0}}, rd_val0}, {{(N-1){1'b0}}, model[rd_idx0]});
        check(tag, "rd_val1", {{(N-1){1'b0}}, rd_val1}, {{(N-1){1'b0}}, model[rd_idx1]});
        check(tag, "conflict", {{(N-1){1'b0}}, conflict}, {{(N-1){1'b0}}, exp_conf});
        if (coll_we) nxt = coll_wdata;
        else begin
            nxt = model;
            for (int i = 0; i < N; i++) begin
                if (clr_mask[i]) nxt[i] = 1'b0;
                if (set_mask[i]) nxt[i] = 1'b1;
                if (ones[i])     nxt[i] = 1'b1;
                if (zeros[i])    nxt[i] = 1'b0;
            end
        end
        nxt[0] = 1'b1;
        @(posedge clk);
        model = nxt;
        #0.5;
    endtask

    task automatic idle();
        dep_valid = '0; clr_mask = '0; set_mask = '0; coll_we = 1'b0;
    endtask

    task automatic lane(int l, int ix, int kind, bit g, bit c);
        dep_valid[l] = 1'b1;
        dep_idx[l*IW +: IW] = IW'(ix);
        dep_kind[l*4 +: 4]  = 4'(kind);
        dep_guard[l] = g;
        dep_cmp[l]   = c;
    endtask

    initial begin
        #150000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model = {{(N-1){1'b0}}, 1'b1};
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1'b1;
        // R12: reset state
        step("R12");

        // R2..R7: sweep every kind, guard, result and prior value on register 5
        for (int k = 0; k < 16; k++)
            for (int g = 0; g < 2; g++)
                for (int c = 0; c < 2; c++)
                    for (int p = 0; p < 2; p++) begin
                        idle(); coll_we = 1'b1; coll_wdata = N'(p) << 5;
                        step(tag_of_kind(k));
                        idle(); rd_idx0 = 5'd5; lane(0, 5, k, g[0], c[0]);
                        step(k < 12 ? tag_of_kind(k) : "R7");
                        idle();
                        step(k < 12 ? tag_of_kind(k) : "R7");
                    end

        // R8: parallel or-kinds and and-kinds on one register
        idle(); clr_mask = '1; step("R8");
        idle(); rd_idx0 = 5'd7;
        lane(0, 7, 2, 1, 0); lane(1, 7, 3, 1, 0); lane(2, 7, 8, 0, 0); lane(3, 7, 2, 0, 1);
        step("R8"); idle(); step("R8");
        lane(0, 7, 4, 1, 1); lane(1, 7, 5, 1, 0); lane(2, 7, 10, 1, 0); lane(3, 7, 10, 1, 1);
        step("R8"); idle(); step("R8");
        // R8: mixed write of 1 and write of 0 to one register -> 0 wins, conflict
        lane(0, 9, 2, 1, 1); lane(1, 9, 4, 1, 0); step("R8"); idle(); rd_idx1 = 5'd9; step("R8");
        // conflict on entry 0 is not reported
        lane(0, 0, 2, 1, 1); lane(1, 0, 4, 1, 0); step("R8"); idle(); step("R8");

        // R9: overlapping masks, then masks under deposits
        clr_mask = 32'hFFFF_0000; set_mask = 32'h00FF_FF00; step("R9"); idle(); step("R9");
        clr_mask = 32'h0000_0F00; set_mask = 32'h0000_0030;
        lane(0, 9, 0, 1, 1); lane(1, 5, 1, 1, 1); step("R9"); idle(); step("R9");

        // R10: word load discards masks and deposits of the same cycle
        coll_we = 1'b1; coll_wdata = 32'hA5C3_0F96; clr_mask = '1;
        lane(0, 3, 0, 1, 0); lane(1, 4, 2, 1, 1); step("R10"); idle(); step("R10");

        // R1: entry 0 under every write path
        coll_we = 1'b1; coll_wdata = 32'h0; step("R1"); idle(); rd_idx0 = 5'd0; step("R1");
        clr_mask = 32'h1; step("R1"); idle(); step("R1");
        lane(0, 0, 0, 0, 0); lane(1, 0, 4, 1, 0); lane(2, 0, 10, 0, 0); step("R1"); idle(); step("R1");

        // R11: random mixed traffic with read ports
        for (int t = 0; t < 3000; t++) begin
            idle();
            for (int l = 0; l < L; l++)
                if ($urandom_range(0, 2) != 0)
                    lane(l, $urandom_range(0, 7), $urandom_range(0, 13), 1'($urandom), 1'($urandom));
            if ($urandom_range(0, 9) == 0) clr_mask = $urandom & $urandom;
            if ($urandom_range(0, 9) == 0) set_mask = $urandom & $urandom;
            if ($urandom_range(0, 29) == 0) begin coll_we = 1'b1; coll_wdata = $urandom; end
            rd_idx0 = 5'($urandom_range(0, 7));
            rd_idx1 = 5'($urandom);
            step("R11");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule